// File: doc/BRIEF.md
# Debug instruction and data transfer chains

This block holds the two debug scan chains that sit between a test access port and a processor core. The instruction chain carries a 32-bit instruction word from the host into a latch. The data chain moves 32-bit words in either direction, together with handshake flags. The block follows the port's state strobes (capture, shift, update and a Run-Test/Idle level) and the chain number and access mode selected by the host. It also decides when the latched instruction is handed to the core.

The instruction is handed over only when Run-Test/Idle is entered. At that moment the instruction chain (4) or the data chain (5) must be selected, together with one of the two access modes. The host tracks progress by capturing the chains and shifting them out. On the instruction chain it sees a completion flag. On the data chain it sees a ready flag and a retry flag.

Top module: `dbg_xfer_chains`

## Requirements
- R1: After reset, `instr_valid`, `to_core_full` and `fc_take` are 0 and the completion flag reads 1.
- R2: With chain_sel = 4 and mode 1 (internal) or 2 (external), capture loads bits 31..0 with the latched instruction and bit 32 with the completion flag. Shift moves the chain one bit toward `tdo` each cycle, and `tdi` enters at bit 32. Update latches bits 31..0 onto `instr_word`. `tdo` shows bit 0 and is 0 while neither chain is active.
- R3: The data chain is 34 bits: 31..0 data, 32 ready, 33 retry-not-needed. With mode 2, capture loads 0 into the data bits, the inverse of `to_core_full` into bit 32, and the inverse of the drop flag into bit 33. It then clears the drop flag. `tdi` enters at bit 33.
- R4: With chain 5 and mode 2, an update while `to_core_full` is 0 copies bits 31..0 to `to_core_data` and sets `to_core_full` on the next cycle.
- R5: An update with mode 2 while `to_core_full` is 1 leaves `to_core_data` unchanged and sets the drop flag. The next mode-2 capture then reads bit 33 as 0.
- R6: With chain 5 and mode 1, capture loads `fc_data` into bits 31..0, `fc_valid` into bit 32 and 1 into bit 33. `fc_take` pulses for one cycle after that capture only if `fc_valid` was 1.
- R7: When `run_idle` rises and chain 4 or 5 is selected with mode 1 or 2, `instr_valid` is 1 for exactly the next cycle.
- R8: Holding `run_idle` high for several cycles gives no further `instr_valid` pulse until it falls and rises again.
- R9: When chain 0 is selected, or when the mode is 0, entering Run-Test/Idle gives no `instr_valid` pulse.
- R10: The completion flag clears on the cycle the instruction is issued and sets after a cycle with `instr_done` high.
- R11: A cycle with `to_core_take` high and no accepted write clears `to_core_full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low reset |
| capture_dr | input | 1 | Capture state strobe |
| shift_dr | input | 1 | Shift state strobe |
| update_dr | input | 1 | Update state strobe |
| run_idle | input | 1 | High while in Run-Test/Idle |
| tdi | input | 1 | Serial data in |
| chain_sel | input | 5 | Active chain number |
| mode | input | 2 | Access mode: 1 internal, 2 external, others none |
| tdo | output | 1 | Serial data out |
| instr_word | output | 32 | Latched instruction to core |
| instr_valid | output | 1 | One-cycle issue pulse |
| instr_done | input | 1 | Core reports instruction complete |
| to_core_data | output | 32 | Host-to-core data word |
| to_core_full | output | 1 | Host-to-core word waiting |
| to_core_take | input | 1 | Core consumed the host-to-core word |
| fc_data | input | 32 | Core-to-host data word |
| fc_valid | input | 1 | Core-to-host word is valid |
| fc_take | output | 1 | Core-to-host word was captured |

## Verification
The issue rule is exercised in four ways: a long stay in Run-Test/Idle, which separates edge detection from level detection; entry with chain 0 and entry with no access mode, which show that the chain and mode gate the issue; and entry from the data chain. Writes to the core are tried once into an empty register and once into a full one, to tell an accepted write from a dropped one and to show that the retry flag is reported once and then cleared. Reads from the core are captured with the word valid and with it not valid, which separates the take pulse from capture alone. A core stub answers each issue after a delay, so the completion flag is read both before and after the answer.

// File: rtl/dbg_xfer_chains.sv
module dbg_xfer_chains #(
  parameter int DW = 32,
  parameter int SEL_W = 5,
  parameter int INSTR_CHAIN = 4,
  parameter int DATA_CHAIN = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture_dr,
  input  logic          shift_dr,
  input  logic          update_dr,
  input  logic          run_idle,
  input  logic          tdi,
  input  logic [SEL_W-1:0] chain_sel,
  input  logic [1:0]    mode,
  output logic          tdo,
  output logic [DW-1:0] instr_word,
  output logic          instr_valid,
  input  logic          instr_done,
  output logic [DW-1:0] to_core_data,
  output logic          to_core_full,
  input  logic          to_core_take,
  input  logic [DW-1:0] fc_data,
  input  logic          fc_valid,
  output logic          fc_take
);
  localparam int IW = DW + 1;
  localparam int XW = DW + 2;
  localparam logic [1:0] M_INT = 2'd1;
  localparam logic [1:0] M_EXT = 2'd2;

  logic [XW-1:0] sr;
  logic done_q, drop_q, rti_q;

  wire access   = (mode == M_INT) || (mode == M_EXT);
  wire ichain   = access && (chain_sel == SEL_W'(INSTR_CHAIN));
  wire dchain   = access && (chain_sel == SEL_W'(DATA_CHAIN));
  wire wr_req   = update_dr && dchain && (mode == M_EXT);
  wire issue    = run_idle && !rti_q && (ichain || dchain);

  assign tdo = (ichain || dchain) & sr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0;
    end else if (capture_dr && ichain) begin
      sr <= {1'b0, done_q, instr_word};
    end else if (capture_dr && dchain) begin
      if (mode == M_EXT) sr <= {~drop_q, ~to_core_full, {DW{1'b0}}};
      else               sr <= {1'b1, fc_valid, fc_data};
    end else if (shift_dr && ichain) begin
      sr[IW-1:0] <= {tdi, sr[IW-1:1]};
    end else if (shift_dr && dchain) begin
      sr <= {tdi, sr[XW-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instr_word   <= '0;
      to_core_data <= '0;
      to_core_full <= 1'b0;
      drop_q       <= 1'b0;
      fc_take      <= 1'b0;
      rti_q        <= 1'b0;
      instr_valid  <= 1'b0;
      done_q       <= 1'b1;
    end else begin
      if (update_dr && ichain) instr_word <= sr[DW-1:0];
      if (wr_req && !to_core_full) begin
        to_core_data <= sr[DW-1:0];
        to_core_full <= 1'b1;
      end else if (to_core_take) begin
        to_core_full <= 1'b0;
      end
      if (capture_dr && dchain && mode == M_EXT) drop_q <= 1'b0;
      else if (wr_req && to_core_full)           drop_q <= 1'b1;
      fc_take     <= capture_dr && dchain && (mode == M_INT) && fc_valid;
      rti_q       <= run_idle;
      instr_valid <= issue;
      if (issue)           done_q <= 1'b0;
      else if (instr_done) done_q <= 1'b1;
    end
  end

  a_r8_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |=> !instr_valid);
  a_r7_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |-> $past(run_idle) && $rose(rti_q));
  a_r10_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |-> !done_q);
  a_r5_drop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && to_core_full) |=> $stable(to_core_data) && drop_q);
  a_r4_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !to_core_full) |=> to_core_full);
  a_r6_take_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fc_take |-> $past(fc_valid) && $past(capture_dr));
endmodule

// File: tb/tb_dbg_xfer_chains.sv
module tb_dbg_xfer_chains;
  logic clk = 0, rst_n = 0;
  logic capture_dr = 0, shift_dr = 0, update_dr = 0, run_idle = 0, tdi = 0;
  logic [4:0] chain_sel = 0;
  logic [1:0] mode = 0;
  logic tdo, instr_valid, to_core_full, fc_take;
  logic [31:0] instr_word, to_core_data;
  logic instr_done = 0, to_core_take = 0, fc_valid = 0;
  logic [31:0] fc_data = 0;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dbg_xfer_chains dut (.clk(clk), .rst_n(rst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .run_idle(run_idle), .tdi(tdi), .chain_sel(chain_sel), .mode(mode),
    .tdo(tdo), .instr_word(instr_word), .instr_valid(instr_valid), .instr_done(instr_done),
    .to_core_data(to_core_data), .to_core_full(to_core_full), .to_core_take(to_core_take),
    .fc_data(fc_data), .fc_valid(fc_valid), .fc_take(fc_take));

  // reference model
  bit q[$];
  logic [31:0] m_instr, m_tcd;
  bit m_done, m_full, m_drop, m_valid, m_take, m_rti;
  int pulses = 0, takes = 0;

  function automatic bit act();
    return (mode == 1 || mode == 2) && (chain_sel == 4 || chain_sel == 5);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q = {}; for (int i = 0; i < 34; i++) q.push_back(0);
      m_instr = 0; m_tcd = 0; m_done = 1; m_full = 0; m_drop = 0;
      m_valid = 0; m_take = 0; m_rti = 0;
    end else begin
      bit nv, nt;
      nv = run_idle && !m_rti && act();
      m_rti = run_idle;
      nt = 0;
      if (capture_dr && act()) begin
        q = {};
        if (chain_sel == 4) begin
          for (int i = 0; i < 32; i++) q.push_back(m_instr[i]);
          q.push_back(m_done);
        end else if (mode == 2) begin
          for (int i = 0; i < 32; i++) q.push_back(0);
          q.push_back(!m_full); q.push_back(!m_drop);
          m_drop = 0;
        end else begin
          for (int i = 0; i < 32; i++) q.push_back(fc_data[i]);
          q.push_back(fc_valid); q.push_back(1);
          nt = fc_valid;
        end
      end else if (shift_dr && act()) begin
        void'(q.pop_front()); q.push_back(tdi);
      end else if (update_dr && act()) begin
        if (chain_sel == 4) for (int i = 0; i < 32; i++) m_instr[i] = q[i];
        else if (mode == 2) begin
          if (!m_full) begin
            for (int i = 0; i < 32; i++) m_tcd[i] = q[i];
            m_full = 1;
          end else m_drop = 1;
        end
      end
      if (!(update_dr && act() && chain_sel == 5 && mode == 2) && to_core_take) m_full = 0;
      if (nv) m_done = 0; else if (instr_done) m_done = 1;
      m_valid = nv; m_take = nt;
    end
  end

  task automatic chk(string req, logic [33:0] act_v, logic [33:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    chk("R7 model instr_valid", instr_valid, m_valid);
    chk("R2 model instr_word", instr_word, m_instr);
    chk("R4 model to_core_full", to_core_full, m_full);
    chk("R4 model to_core_data", to_core_data, m_tcd);
    chk("R6 model fc_take", fc_take, m_take);
    chk("R2 model tdo", tdo, act() ? q[0] : 1'b0);
    if (instr_valid) pulses++;
    if (fc_take) takes++;
  end

  // core stub: answers each issue after a delay
  int stub_cnt = 0;
  always @(negedge clk) begin
    instr_done = 0;
    if (stub_cnt > 0) begin stub_cnt--; if (stub_cnt == 0) instr_done = 1; end
    if (instr_valid) stub_cnt = 20;
  end

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic scan(input logic [33:0] din, input int len, input bit upd, output logic [33:0] dout);
    dout = 0;
    capture_dr = 1; tick(); capture_dr = 0;
    for (int i = 0; i < len; i++) begin
      shift_dr = 1; tdi = din[i]; dout[i] = tdo; tick();
    end
    shift_dr = 0; tdi = 0;
    if (upd) begin update_dr = 1; tick(); update_dr = 0; end
    tick();
  endtask

  task automatic idle(input int n);
    run_idle = 1; repeat (n) tick(); run_idle = 0; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [33:0] d;
    int p0;
    repeat (3) tick();
    chk("R1 reset instr_valid", instr_valid, 0);
    chk("R1 reset to_core_full", to_core_full, 0);
    chk("R1 reset fc_take", fc_take, 0);
    rst_n = 1; tick();

    chain_sel = 4; mode = 2;
    scan(34'h0_E1A0_1234, 33, 1, d);
    chk("R1 done flag after reset", d[32], 1);
    chk("R2 captured old instr", d[31:0], 0);
    chk("R2 instr_word latched", instr_word, 32'hE1A0_1234);
    scan(34'h0, 33, 0, d);
    chk("R2 readback instr", d[31:0], 32'hE1A0_1234);

    p0 = pulses; idle(6);
    chk("R7 R8 one pulse on long idle", pulses - p0, 1);
    scan(34'h0, 33, 0, d);
    chk("R10 done cleared after issue", d[32], 0);
    repeat (25) tick();
    scan(34'h0, 33, 0, d);
    chk("R10 done set by core", d[32], 1);
    p0 = pulses; idle(2); idle(2);
    chk("R8 re-entry issues again", pulses - p0, 2);
    repeat (25) tick();

    chain_sel = 0; p0 = pulses; idle(4);
    chk("R9 chain 0 no issue", pulses - p0, 0);
    chain_sel = 5; mode = 0; p0 = pulses; idle(4);
    chk("R9 no mode no issue", pulses - p0, 0);

    mode = 2;
    scan({2'b00, 32'hCAFE_0001}, 34, 1, d);
    chk("R3 ready when empty", d[32], 1);
    chk("R3 retry flag clear", d[33], 1);
    chk("R3 data bits zero", d[31:0], 0);
    chk("R4 write accepted", to_core_data, 32'hCAFE_0001);
    chk("R4 full set", to_core_full, 1);
    scan({2'b00, 32'h0BAD_0002}, 34, 1, d);
    chk("R3 not ready when full", d[32], 0);
    chk("R5 dropped write keeps data", to_core_data, 32'hCAFE_0001);
    scan(34'h0, 34, 0, d);
    chk("R5 drop reported", d[33], 0);
    to_core_take = 1; tick(); to_core_take = 0; tick();
    chk("R11 take clears full", to_core_full, 0);
    scan(34'h0, 34, 0, d);
    chk("R5 drop reported once", d[33], 1);
    chk("R11 ready after take", d[32], 1);
    p0 = pulses; idle(3);
    chk("R7 data chain issues", pulses - p0, 1);
    repeat (25) tick();

    mode = 1; fc_data = 32'h5A5A_C3C3; fc_valid = 1; p0 = takes;
    scan(34'h0, 34, 0, d);
    chk("R6 captured data", d[31:0], 32'h5A5A_C3C3);
    chk("R6 ready valid", d[32], 1);
    chk("R6 retry bit high", d[33], 1);
    chk("R6 one take pulse", takes - p0, 1);
    fc_valid = 0; p0 = takes;
    scan(34'h0, 34, 0, d);
    chk("R6 not ready", d[32], 0);
    chk("R6 no take when invalid", takes - p0, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule